// File: doc/BRIEF.md
# Multicast Group Vector Table Access Port

This block holds a table of multicast group vectors, each a 32-bit mask with one bit per output port. Software reaches the table indirectly over a byte-wide register bus. It loads an entry number into an index register and stages a vector in a 32-bit data register. A write to a command register then performs one transfer between the data register and the indexed table entry.

The command byte holds two controls. A direction bit chooses between storing the data register into the table and loading the table entry into the data register. A step bit makes the index advance by one after the transfer. With the step bit set, a whole table can be filled or dumped as a stream of byte writes, with no index update between entries. Every transfer completes on the clock edge that accepts the command write. The result can be read on the next bus cycle.

Register map (4-bit address): 0x0 to 0x3 are the data register bytes, with address k holding bits 8k+7:8k. 0x4 is the index. 0x8 is the command register: bit 0 is the direction and bit 1 is the step. All other addresses read as zero.

Top module: `mcast_table_port`

## Requirements
- R1: After reset, the index, the data register and the command register read as 0, and every table entry holds 0.
- R2: The data register is written and read as four bytes at addresses 0x0 to 0x3. Address k maps to bits 8k+7:8k.
- R3: The index register at address 0x4 is directly writable and reads back the value last written.
- R4: A command write to 0x8 with bit 0 = 1 stores the data register into the entry selected by the index, on that same edge. The data register is unchanged.
- R5: A command write with bit 0 = 0 copies the indexed entry into the data register on that edge. The new value is readable on the next bus read.
- R6: With command bit 1 = 1, the index advances by one after the transfer and wraps from 255 to 0.
- R7: With command bit 1 = 0, the index keeps its value after the transfer.
- R8: The command register reads back bits 1:0 of the last command. Bits 7:2 read as 0 and have no effect on the transfer.
- R9: A store changes only the indexed entry. All other entries keep their contents.
- R10: Writes to unmapped addresses change no register and no entry, and reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe, one cycle per byte written |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |

## Verification
The table is filled in a single stepping-store pass with a distinct pseudo-random vector in every entry. It is then dumped in a stepping-load pass. Because each entry differs, a wrong index, a missed step or a swapped byte lane cannot go unnoticed. The end index of each pass shows whether the index wraps at 255. Non-stepping store and load commands separate the step control from the direction control. A single store into a filled table, followed by reads of its neighbours, shows that the write decode selects exactly one entry. Command bytes with the upper bits set, and writes to unmapped addresses, show that these inputs change nothing.

// File: rtl/mtp_pkg.sv
package mtp_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] ADDR_IDX = 4'h4;
  localparam logic [ADDR_W-1:0] ADDR_OP  = 4'h8;

  // command byte, low two bits
  typedef struct packed {
    logic step;   // bit 1: advance index after transfer
    logic store;  // bit 0: 1 = data -> table, 0 = table -> data
  } cmd_t;
endpackage

// File: rtl/mtp_table.sv
module mtp_table #(
  parameter int VEC_W = 32,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [VEC_W-1:0] wdata,
  output logic [VEC_W-1:0] rd_vec
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [VEC_W-1:0] mem [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic hit;
    assign hit = wr_en && (idx == IDX_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem[e] <= '0;
      else if (hit) mem[e] <= wdata;
    end
  end

  assign rd_vec = mem[idx];
endmodule

// File: rtl/mtp_regs.sv
module mtp_regs
  import mtp_pkg::*;
#(
  parameter int VEC_W = 32,
  parameter int IDX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [VEC_W-1:0]  rd_vec,
  output logic              xfer_fire,
  output logic              xfer_store,
  output logic              xfer_step,
  output logic [IDX_W-1:0]  idx_q,
  output logic [VEC_W-1:0]  data_q
);
  localparam int NBYTES = VEC_W / 8;

  function automatic logic [IDX_W-1:0] next_index(input logic [IDX_W-1:0] cur);
    return cur + IDX_W'(1);
  endfunction

  cmd_t cmd_in, cmd_q;
  logic [7:0] data_b [NBYTES];

  assign cmd_in     = cmd_t'(reg_wdata[1:0]);
  assign xfer_fire  = reg_wr && (reg_addr == ADDR_OP);
  assign xfer_store = cmd_in.store;
  assign xfer_step  = cmd_in.step;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        data_b[b] <= '0;
      else if (reg_wr && (reg_addr == ADDR_W'(b)))
        data_b[b] <= reg_wdata;
      else if (xfer_fire && !xfer_store)
        data_b[b] <= rd_vec[8*b +: 8];
    end
    assign data_q[8*b +: 8] = data_b[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idx_q <= '0;
    else if (reg_wr && (reg_addr == ADDR_IDX))
      idx_q <= reg_wdata[IDX_W-1:0];
    else if (xfer_fire && xfer_step)
      idx_q <= next_index(idx_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cmd_q <= '0;
    else if (xfer_fire) cmd_q <= cmd_in;
  end

  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < NBYTES; b++)
      if (reg_addr == ADDR_W'(b)) reg_rdata = data_b[b];
    if (reg_addr == ADDR_IDX) reg_rdata = 8'(idx_q);
    if (reg_addr == ADDR_OP)  reg_rdata = {6'b0, cmd_q};
  end
endmodule

// File: rtl/mcast_table_port.sv
module mcast_table_port
  import mtp_pkg::*;
#(
  parameter int VEC_W = 32,
  parameter int IDX_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata
);
  logic             xfer_fire, xfer_store, xfer_step;
  logic [IDX_W-1:0] idx_q;
  logic [VEC_W-1:0] data_q, rd_vec;
  logic             tbl_wr;

  assign tbl_wr = xfer_fire && xfer_store;

  mtp_regs #(.VEC_W(VEC_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rd_vec(rd_vec),
    .xfer_fire(xfer_fire), .xfer_store(xfer_store), .xfer_step(xfer_step),
    .idx_q(idx_q), .data_q(data_q)
  );

  mtp_table #(.VEC_W(VEC_W), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n), .wr_en(tbl_wr), .idx(idx_q),
    .wdata(data_q), .rd_vec(rd_vec)
  );
endmodule

// File: rtl/mtp_checker.sv
module mtp_checker
  import mtp_pkg::*;
#(
  parameter int VEC_W = 32,
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       reg_addr,
  input logic [7:0]       reg_rdata,
  input logic             xfer_fire,
  input logic             xfer_store,
  input logic             xfer_step,
  input logic [IDX_W-1:0] idx_q,
  input logic [VEC_W-1:0] data_q,
  input logic [VEC_W-1:0] rd_vec
);
  AST_RST_CLEAR: assert property (@(posedge clk) $rose(rst_n) |-> (idx_q == '0 && data_q == '0)); // R1
  AST_STORE_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n) xfer_fire && xfer_store |=> $stable(data_q)); // R4
  AST_STORE_LANDS: assert property (@(posedge clk) disable iff (!rst_n) xfer_fire && xfer_store && !xfer_step |=> rd_vec == $past(data_q)); // R4
  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n) xfer_fire && !xfer_store |=> data_q == $past(rd_vec)); // R5
  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n) xfer_fire && xfer_step |=> idx_q == IDX_W'($past(idx_q) + 1'b1)); // R6
  AST_NO_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) xfer_fire && !xfer_step |=> $stable(idx_q)); // R7
  AST_CMD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n) reg_addr == ADDR_OP |-> reg_rdata[7:2] == 6'b0); // R8
endmodule

bind mcast_table_port mtp_checker #(.VEC_W(VEC_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .xfer_fire(xfer_fire), .xfer_store(xfer_store), .xfer_step(xfer_step),
  .idx_q(idx_q), .data_q(data_q), .rd_vec(rd_vec)
);

// File: tb/tb_mcast_table_port.sv
`timescale 1ns/1ps
module tb_mcast_table_port;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [3:0] reg_addr = '0;
  logic       reg_wr = 0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;

  int checks = 0, fails = 0;
  logic [31:0] ref_tbl [256];
  bit done = 0;

  mcast_table_port dut (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr),
                        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  always #5 clk = ~clk;

  function automatic logic [31:0] pattern(input int i);
    logic [31:0] h = 32'h9E3779B9 * 32'(i + 1);
    return h ^ {8'(i), 8'(255 - i), 8'(i * 7), 8'(i ^ 8'h5a)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic put_vec(input logic [31:0] v);
    for (int b = 0; b < 4; b++) wr(4'(b), v[8*b +: 8]);
  endtask

  task automatic get_vec(output logic [31:0] v);
    logic [7:0] t;
    for (int b = 0; b < 4; b++) begin rd(4'(b), t); v[8*b +: 8] = t; end
  endtask

  task automatic get_idx(output logic [7:0] v); rd(4'h4, v); endtask

  task automatic t_reset;
    logic [31:0] v; logic [7:0] x;
    get_vec(v); check("R1 data", v, 0);
    get_idx(x); check("R1 index", 32'(x), 0);
    rd(4'h8, x); check("R1 cmd", 32'(x), 0);
    foreach (ref_tbl[i]) ref_tbl[i] = '0;
    put_vec(32'hFFFF_FFFF);
    wr(4'h4, 8'd0);   wr(4'h8, 8'h00); get_vec(v); check("R1 entry0", v, 0);
    put_vec(32'hFFFF_FFFF);
    wr(4'h4, 8'd128); wr(4'h8, 8'h00); get_vec(v); check("R1 entry128", v, 0);
    put_vec(32'hFFFF_FFFF);
    wr(4'h4, 8'd255); wr(4'h8, 8'h00); get_vec(v); check("R1 entry255", v, 0);
  endtask

  task automatic t_bytes;
    logic [7:0] x;
    wr(4'h0, 8'h11); wr(4'h1, 8'h22); wr(4'h2, 8'h33); wr(4'h3, 8'h44);
    for (int b = 0; b < 4; b++) begin
      rd(4'(b), x); check("R2 byte lane", 32'(x), 32'(8'h11 * (b + 1)));
    end
    wr(4'h4, 8'hA7); get_idx(x); check("R3 index rw", 32'(x), 32'hA7);
    wr(4'h4, 8'h3C); get_idx(x); check("R3 index rw", 32'(x), 32'h3C);
  endtask

  task automatic t_fill_dump;
    logic [31:0] v; logic [7:0] x;
    wr(4'h4, 8'd0);
    for (int i = 0; i < 256; i++) begin
      ref_tbl[i] = pattern(i);
      put_vec(ref_tbl[i]);
      wr(4'h8, 8'h03);
      if (i == 0) begin get_vec(v); check("R4 data kept", v, ref_tbl[0]); end
    end
    get_idx(x); check("R6 wrap after fill", 32'(x), 0);
    rd(4'h8, x); check("R8 cmd readback", 32'(x), 32'h3);
    for (int i = 0; i < 256; i++) begin
      wr(4'h8, 8'h02);
      get_vec(v); check("R5 dump entry", v, ref_tbl[i]);
    end
    get_idx(x); check("R6 wrap after dump", 32'(x), 0);
  endtask

  task automatic t_no_step;
    logic [31:0] v; logic [7:0] x;
    wr(4'h4, 8'd10); put_vec(32'hCAFE_0A0A); wr(4'h8, 8'h01);
    ref_tbl[10] = 32'hCAFE_0A0A;
    get_idx(x); check("R7 idx held store", 32'(x), 10);
    put_vec(32'h0); wr(4'h8, 8'h00);
    get_idx(x); check("R7 idx held load", 32'(x), 10);
    get_vec(v); check("R5 load no-step", v, 32'hCAFE_0A0A);
  endtask

  task automatic t_neighbours;
    logic [31:0] v;
    wr(4'h4, 8'd20); put_vec(32'h1234_5678); wr(4'h8, 8'h01);
    ref_tbl[20] = 32'h1234_5678;
    wr(4'h4, 8'd19);
    for (int i = 19; i <= 21; i++) begin
      wr(4'h8, 8'h02); get_vec(v); check("R9 single entry", v, ref_tbl[i]);
    end
  endtask

  task automatic t_upper_bits;
    logic [31:0] v; logic [7:0] x;
    wr(4'h4, 8'd50); put_vec(32'hBEEF_0050); wr(4'h8, 8'hFD);
    ref_tbl[50] = 32'hBEEF_0050;
    rd(4'h8, x); check("R8 upper bits read 0", 32'(x), 32'h1);
    get_idx(x); check("R8 upper bits no step", 32'(x), 50);
    put_vec(32'h0); wr(4'h8, 8'hFC);
    get_vec(v); check("R8 0xFC acts as load", v, 32'hBEEF_0050);
    get_idx(x); check("R8 0xFC no step", 32'(x), 50);
  endtask

  task automatic t_unmapped;
    logic [31:0] v; logic [7:0] x;
    put_vec(32'h5555_AAAA); wr(4'h4, 8'd7);
    wr(4'h5, 8'hFF); wr(4'h9, 8'hFF); wr(4'hF, 8'hFF);
    rd(4'h5, x); check("R10 read 0x5", 32'(x), 0);
    rd(4'hF, x); check("R10 read 0xF", 32'(x), 0);
    get_vec(v); check("R10 data kept", v, 32'h5555_AAAA);
    get_idx(x); check("R10 index kept", 32'(x), 7);
    wr(4'h8, 8'h00); get_vec(v); check("R10 entry kept", v, ref_tbl[7]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_bytes();
    t_fill_dump();
    t_no_step();
    t_neighbours();
    t_upper_bits();
    t_unmapped();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule